// File: doc/BRIEF.md
# Endian-Aware Sub-Word Lane Router

This block sits between the load/store path of a core and a memory data bus of the same width. For stores it copies a byte or halfword onto every matching lane of the bus and marks the lanes that hold the addressed item with byte enables. For loads it picks the addressed byte or halfword out of the returned bus word and widens it to the full width with zero or sign fill. A single endian control input decides which bus lanes a given byte offset inside a word uses. Full-word accesses and instruction fetches move through unchanged in either endian mode.

An access is accepted in the cycle where `req_valid` is high. The store data, the byte enables and the misalignment flag are combinational outputs of that cycle. For a load, memory presents `bus_rdata` in the following cycle, and the widened result appears on `ld_data` together with `ld_valid` in that same following cycle. The endian bit, the size, the offset and the signedness of a load are captured when the load is accepted, so later changes to those inputs do not disturb a load that is already in flight.

Top module: `endian_lane_router`

## Requirements
- R1: A byte access (`req_size` = 2'b00) at offset o asserts only byte enable bit o when `big_end` = 0, and only bit 3-o when `big_end` = 1. Bit k of `bus_be` covers `bus_wdata[8k+7:8k]`.
- R2: A halfword access (`req_size` = 2'b01) at offset 0 asserts enables 4'b0011 in little endian and 4'b1100 in big endian. At offset 2 it asserts 4'b1100 in little endian and 4'b0011 in big endian.
- R3: `bus_wdata` carries the low byte of `st_data` on all four lanes for a byte access, the low halfword on both halves for a halfword access, and `st_data` unchanged for a word or fetch.
- R4: A word (2'b10) or fetch (2'b11) access asserts `bus_be` = 4'hF, and its store data and load result do not depend on `big_end`.
- R5: A halfword access with offset bit 0 set raises `misalign` and drives `bus_be` = 0. If it is a load, it returns `ld_data` = 0 along with `ld_valid`.
- R6: An unsigned load (`req_signed` = 0) returns the addressed byte or halfword with zeros above it. Within a word, offset o is the low byte of a halfword in little endian and the high byte in big endian. Lane selection follows R1 and R2.
- R7: A signed load (`req_signed` = 1) of a byte or halfword fills the upper bits with the item's top bit. Word and fetch loads ignore `req_signed`.
- R8: `ld_valid` is high exactly in the cycle after an accepted load (`req_valid` = 1, `req_write` = 0), and is low after stores and idle cycles.
- R9: The endian mode, size, offset and signedness used for a load result are the values present when the load was accepted.
- R10: While `rst_n` is low, and after its release until a load is accepted, `ld_valid` and `ld_data` are 0.
- R11: When `req_valid` is 0, `bus_be` is 0 and `misalign` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Access accepted this cycle |
| req_write | input | 1 | 1 = store, 0 = load or fetch |
| req_size | input | 2 | 00 byte, 01 halfword, 10 word, 11 fetch |
| req_offset | input | 2 | Byte offset within the word |
| req_signed | input | 1 | Sign-extend a sub-word load |
| big_end | input | 1 | 1 = big endian lane order |
| st_data | input | 32 | Store data from the core, right-aligned |
| bus_wdata | output | 32 | Lane-replicated store data to memory |
| bus_be | output | 4 | Byte enables to memory |
| misalign | output | 1 | Halfword at an odd offset |
| bus_rdata | input | 32 | Read data from memory, one cycle after the request |
| ld_valid | output | 1 | Load result valid |
| ld_data | output | 32 | Extended load result |

## Verification
The bench sweeps every offset and size in both endian modes. A design with mirrored lanes would return the neighbouring byte and assert the wrong enable. It also issues odd-offset halfwords: a design that skipped that check would write two lanes and return real data. Signed loads use data whose top item bit is set, so a missing or misplaced sign fill shows up at once. The bench also flips `big_end` and `req_signed` in the cycle after a load is accepted. A design that read these inputs live instead of capturing them would then return data from the wrong lane or with the wrong fill.

// File: rtl/lane_steer_pkg.sv
// Shared access-size encoding for the lane router.
// Assumes a two-bit size field driven by the core's load/store path.
package lane_steer_pkg;
    typedef enum logic [1:0] {
        SZ_BYTE  = 2'b00,
        SZ_HALF  = 2'b01,
        SZ_WORD  = 2'b10,
        SZ_FETCH = 2'b11
    } acc_size_e;
endpackage

// File: rtl/lane_map.sv
// Maps (size, offset, endian) to a starting lane, a byte-enable mask and a
// misalignment flag. Assumes NL is a power of two and at least 2.
module lane_map
    import lane_steer_pkg::*;
#(
    parameter int unsigned NL = 4,
    localparam int unsigned OW = $clog2(NL)
) (
    input  acc_size_e         size,
    input  logic [OW-1:0]     offset,
    input  logic              big,
    output logic [OW-1:0]     lane,
    output logic [NL-1:0]     be,
    output logic              misalign
);
    localparam logic [OW-1:0] BYTE_FLIP = OW'(NL - 1);
    localparam logic [OW-1:0] HALF_FLIP = OW'(NL - 2);
    localparam logic [NL-1:0] ONE_LANE  = NL'(1);
    localparam logic [NL-1:0] TWO_LANES = NL'(3);

    // Select the lowest lane of the addressed item and build its enable mask.
    always_comb begin
        lane     = '0;
        be       = '0;
        misalign = 1'b0;
        unique case (size)
            SZ_BYTE: begin
                lane = offset ^ (big ? BYTE_FLIP : '0);
                be   = ONE_LANE << lane;
            end
            SZ_HALF: begin
                if (offset[0]) begin
                    misalign = 1'b1;
                end else begin
                    lane = offset ^ (big ? HALF_FLIP : '0);
                    be   = TWO_LANES << lane;
                end
            end
            default: be = '1;
        endcase
    end
endmodule

// File: rtl/store_pack.sv
// Replicates store data across the bus lanes by access size.
// Assumes the core presents sub-word data right-aligned in st_data.
module store_pack
    import lane_steer_pkg::*;
#(
    parameter int unsigned DW = 32,
    localparam int unsigned NL = DW / 8
) (
    input  acc_size_e     size,
    input  logic [DW-1:0] st_data,
    output logic [DW-1:0] bus_wdata
);
    // Copy the byte or halfword onto every lane it may occupy.
    always_comb begin
        unique case (size)
            SZ_BYTE: bus_wdata = {NL{st_data[7:0]}};
            SZ_HALF: bus_wdata = {(NL/2){st_data[15:0]}};
            default: bus_wdata = st_data;
        endcase
    end
endmodule

// File: rtl/load_unpack.sv
// Captures load attributes at acceptance and, one cycle later, extracts and
// widens the addressed item from the returned bus word.
// Assumes memory returns read data in the cycle after the request.
module load_unpack
    import lane_steer_pkg::*;
#(
    parameter int unsigned DW = 32,
    localparam int unsigned NL = DW / 8,
    localparam int unsigned OW = $clog2(NL)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          accept,
    input  acc_size_e     size,
    input  logic [OW-1:0] offset,
    input  logic          big,
    input  logic          sgn,
    input  logic [DW-1:0] bus_rdata,
    output logic          ld_valid,
    output logic [DW-1:0] ld_data
);
    acc_size_e     cap_size;
    logic [OW-1:0] cap_off;
    logic          cap_big;
    logic          cap_sgn;
    logic [OW-1:0] lane;
    logic [NL-1:0] unused_be;
    logic          cap_mis;
    logic [DW-1:0] shifted;
    logic [DW-1:0] widened;

    // Hold the attributes of the accepted load for the data cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ld_valid <= 1'b0;
            cap_size <= SZ_WORD;
            cap_off  <= '0;
            cap_big  <= 1'b0;
            cap_sgn  <= 1'b0;
        end else begin
            ld_valid <= accept;
            if (accept) begin
                cap_size <= size;
                cap_off  <= offset;
                cap_big  <= big;
                cap_sgn  <= sgn;
            end
        end
    end

    lane_map #(.NL(NL)) u_rd_map (
        .size     (cap_size),
        .offset   (cap_off),
        .big      (cap_big),
        .lane     (lane),
        .be       (unused_be),
        .misalign (cap_mis)
    );

    // Move the addressed item down to bit 0 and apply zero or sign fill.
    always_comb begin
        shifted = bus_rdata >> {lane, 3'b000};
        unique case (cap_size)
            SZ_BYTE: widened = {{(DW-8){cap_sgn & shifted[7]}}, shifted[7:0]};
            SZ_HALF: widened = cap_mis ? '0
                             : {{(DW-16){cap_sgn & shifted[15]}}, shifted[15:0]};
            default: widened = bus_rdata;
        endcase
        ld_data = ld_valid ? widened : '0;
    end

    a_r6_unsigned_byte_zero_fill: assert property (@(posedge clk) disable iff (!rst_n)
        (ld_valid && cap_size == SZ_BYTE && !cap_sgn) |-> ld_data[DW-1:8] == '0);
    a_r5_misaligned_load_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (ld_valid && cap_mis) |-> ld_data == '0);
    a_r10_idle_result_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !ld_valid |-> ld_data == '0);
endmodule

// File: rtl/endian_lane_router.sv
// Top of the sub-word lane router: store steering and byte enables on the
// request cycle, extended load result one cycle later.
// Assumes one access per cycle and read data one cycle after a load request.
module endian_lane_router
    import lane_steer_pkg::*;
#(
    parameter int unsigned DW = 32,
    localparam int unsigned NL = DW / 8,
    localparam int unsigned OW = $clog2(NL)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_valid,
    input  logic          req_write,
    input  logic [1:0]    req_size,
    input  logic [OW-1:0] req_offset,
    input  logic          req_signed,
    input  logic          big_end,
    input  logic [DW-1:0] st_data,
    output logic [DW-1:0] bus_wdata,
    output logic [NL-1:0] bus_be,
    output logic          misalign,
    input  logic [DW-1:0] bus_rdata,
    output logic          ld_valid,
    output logic [DW-1:0] ld_data
);
    acc_size_e     size;
    logic [OW-1:0] unused_lane;
    logic [NL-1:0] raw_be;
    logic          raw_mis;

    assign size = acc_size_e'(req_size);

    lane_map #(.NL(NL)) u_wr_map (
        .size     (size),
        .offset   (req_offset),
        .big      (big_end),
        .lane     (unused_lane),
        .be       (raw_be),
        .misalign (raw_mis)
    );

    store_pack #(.DW(DW)) u_pack (
        .size      (size),
        .st_data   (st_data),
        .bus_wdata (bus_wdata)
    );

    // Drive enables and the alignment flag only for an accepted access.
    always_comb begin
        bus_be   = req_valid ? raw_be : '0;
        misalign = req_valid & raw_mis;
    end

    load_unpack #(.DW(DW)) u_unpack (
        .clk       (clk),
        .rst_n     (rst_n),
        .accept    (req_valid & ~req_write),
        .size      (size),
        .offset    (req_offset),
        .big       (big_end),
        .sgn       (req_signed),
        .bus_rdata (bus_rdata),
        .ld_valid  (ld_valid),
        .ld_data   (ld_data)
    );

    a_r1_byte_single_lane: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_size == 2'b00) |-> $countones(bus_be) == 1);
    a_r5_misalign_no_enables: assert property (@(posedge clk) disable iff (!rst_n)
        misalign |-> bus_be == '0);
    a_r4_word_full_lanes: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_size[1]) |-> (bus_be == '1 && bus_wdata == st_data));
    a_r11_idle_no_enables: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |-> (bus_be == '0 && !misalign));
    a_r8_result_follows_load: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_write) |=> ld_valid);
    a_r8_no_spurious_result: assert property (@(posedge clk) disable iff (!rst_n)
        ld_valid |-> $past(req_valid && !req_write));
endmodule

// File: tb/sim_endian_lane_router.sv
`timescale 1ns/1ps
module sim_endian_lane_router;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0, req_write = 1'b0, req_signed = 1'b0, big_end = 1'b0;
    logic [1:0]  req_size = 2'b00, req_offset = 2'b00;
    logic [31:0] st_data = '0, bus_rdata = '0;
    logic [31:0] bus_wdata, ld_data;
    logic [3:0]  bus_be;
    logic        misalign, ld_valid;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    // Pending load recorded by the reference model.
    bit       p_valid = 0;
    bit [1:0] p_size, p_off;
    bit       p_sgn, p_big;

    always #2.5 clk = ~clk;

    endian_lane_router u0 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_size(req_size), .req_offset(req_offset), .req_signed(req_signed),
        .big_end(big_end), .st_data(st_data), .bus_wdata(bus_wdata),
        .bus_be(bus_be), .misalign(misalign), .bus_rdata(bus_rdata),
        .ld_valid(ld_valid), .ld_data(ld_data)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    function automatic int lane_of(bit big, int ofs);
        return big ? 3 - ofs : ofs;
    endfunction

    function automatic bit [7:0] byte_at(bit [31:0] w, bit big, int ofs);
        return w[8*lane_of(big, ofs) +: 8];
    endfunction

    function automatic bit [31:0] model_load(bit [1:0] sz, bit [1:0] ofs, bit sg, bit big,
                                             bit [31:0] w);
        bit [7:0]  b;
        bit [15:0] h;
        case (sz)
            2'b00: begin
                b = byte_at(w, big, ofs);
                return sg ? {{24{b[7]}}, b} : {24'h0, b};
            end
            2'b01: begin
                if (ofs[0]) return 32'h0;
                if (big) h = {byte_at(w, big, ofs), byte_at(w, big, ofs + 1)};
                else     h = {byte_at(w, big, ofs + 1), byte_at(w, big, ofs)};
                return sg ? {{16{h[15]}}, h} : {16'h0, h};
            end
            default: return w;
        endcase
    endfunction

    // One cycle: drive at the falling edge, compare every output, update model.
    task automatic step(input bit v, input bit wr, input bit [1:0] sz, input bit [1:0] ofs,
                        input bit sg, input bit big, input bit [31:0] wd, input bit [31:0] rd);
        bit [3:0]  e_be;
        bit        e_mis;
        bit [31:0] e_wd;
        string     tag;
        @(negedge clk);
        req_valid = v; req_write = wr; req_size = sz; req_offset = ofs;
        req_signed = sg; big_end = big; st_data = wd; bus_rdata = rd;
        #1;
        e_mis = 0;
        case (sz)
            2'b00: begin e_be = 4'b1 << lane_of(big, ofs); e_wd = {4{wd[7:0]}}; tag = "R1"; end
            2'b01: begin
                e_wd = {2{wd[15:0]}}; tag = "R2";
                if (ofs[0]) begin e_be = 4'h0; e_mis = 1; tag = "R5"; end
                else e_be = (4'b1 << lane_of(big, ofs)) | (4'b1 << lane_of(big, ofs + 1));
            end
            default: begin e_be = 4'hF; e_wd = wd; tag = "R4"; end
        endcase
        if (v) begin
            chk({tag, " byte enables"}, {28'h0, bus_be}, {28'h0, e_be});
            chk({tag, " misalign flag"}, {31'h0, misalign}, {31'h0, e_mis});
            chk("R3 store lane data", bus_wdata, e_wd);
        end else begin
            chk("R11 idle enables", {27'h0, misalign, bus_be}, 32'h0);
        end
        chk("R8 load valid timing", {31'h0, ld_valid}, {31'h0, p_valid});
        if (p_valid) begin
            if (p_big != big || p_sgn != sg) tag = "R9 captured attributes";
            else if (p_size == 2'b01 && p_off[0]) tag = "R5 misaligned load";
            else if (p_size[1]) tag = "R4 word load";
            else tag = p_sgn ? "R7 signed load" : "R6 unsigned load";
            chk(tag, ld_data, model_load(p_size, p_off, p_sgn, p_big, rd));
        end else begin
            chk("R10 idle load data", ld_data, 32'h0);
        end
        p_valid = v && !wr;
        p_size = sz; p_off = ofs; p_sgn = sg; p_big = big;
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        #1;
        chk("R10 reset load valid", {31'h0, ld_valid}, 32'h0);
        chk("R10 reset load data", ld_data, 32'h0);
        @(negedge clk);
        rst_n = 1'b1;
        step(0, 0, 2'b00, 0, 0, 0, 32'h0, 32'h0);
        // Stores: every size, offset and endian mode.
        for (int b = 0; b < 2; b++)
            for (int s = 0; s < 4; s++)
                for (int o = 0; o < 4; o++)
                    step(1, 1, 2'(s), 2'(o), 0, b[0], 32'hA1B2C3D4, 32'h0);
        // Loads: sweep with top-bit-set data, both signedness.
        for (int b = 0; b < 2; b++)
            for (int g = 0; g < 2; g++)
                for (int s = 0; s < 4; s++)
                    for (int o = 0; o < 4; o++)
                        step(1, 0, 2'(s), 2'(o), g[0], b[0], 32'h0, 32'h8C7F_F19E);
        step(0, 0, 2'b00, 0, 0, 0, 32'h0, 32'h8C7F_F19E);
        // R9: flip endian and signedness while the load is in flight.
        step(1, 0, 2'b00, 2'd0, 1, 1, 32'h0, 32'h0);
        step(0, 0, 2'b00, 2'd0, 0, 0, 32'h0, 32'hF1223344);
        step(1, 0, 2'b01, 2'd2, 0, 0, 32'h0, 32'h0);
        step(1, 1, 2'b00, 2'd1, 1, 1, 32'h5A, 32'h9988_7766);
        step(0, 0, 2'b00, 2'd0, 0, 0, 32'h0, 32'h0);
        // Random traffic.
        for (int i = 0; i < 600; i++)
            step($urandom_range(0, 3) != 0, $urandom_range(0, 1) == 1,
                 2'($urandom_range(0, 3)), 2'($urandom_range(0, 3)),
                 $urandom_range(0, 1) == 1, $urandom_range(0, 1) == 1,
                 $urandom, $urandom);
        step(0, 0, 2'b00, 0, 0, 0, 32'h0, 32'h0);
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule